// File: doc/BRIEF.md
# Cascadable Serial-Load LED Sink Controller

This block is the digital control core of a multi-channel LED sink driver. A host clocks channel data in one bit at a time on a serial clock. A level-sensitive transfer gate copies the loaded pattern into an output holding stage. The holding stage drives a vector of channel-on bits, where a 1 turns that sink on. Two inputs force every channel off without disturbing stored data: a blanking input and a digital supply-undervoltage flag.

A serial output carries the last stage of the shift chain, retimed on the falling clock edge. It can feed the serial input of another instance, so several devices form one longer chain under a shared clock and transfer gate. An active-low reset clears everything at once. Its release is taken up on a falling clock edge, so the next rising edge shifts cleanly.

Top module: `ledsink_ctrl`

## Requirements
- R1: On each rising edge of `sck` (outside reset), `sdi` enters stage 1 and every stage k>1 takes the old value of stage k-1.
- R2: While `load_open` is 1, the holding stage follows the shift chain, so channel bits change as shifting occurs. While `load_open` is 0, the holding stage keeps its value through any amount of shifting.
- R3: While `blank` is 1, `chan_on` is all zeros in the same cycle. When `blank` returns to 0, the held pattern reappears unchanged.
- R4: While `uv_flag` is 1, `chan_on` is all zeros in the same cycle. When `uv_flag` clears, the held pattern reappears unchanged.
- R5: While `rst_n` is 0, the shift chain, the holding stage and `sdo` are cleared at once, without waiting for a clock edge. `chan_on` reads all zeros.
- R6: `sdo` carries stage N and changes only on a falling edge of `sck`. Between a rising edge and the next falling edge, it still shows the old stage-N value.
- R7: `chan_on[i]` (bit 0 = channel 1) reflects stage i+1. A single 1 shifted in once appears as `chan_on == 16'h0001`.
- R8: After `rst_n` rises, the chain stays cleared until the next falling edge of `sck`. A rising edge before that falling edge does not shift. The first rising edge after it shifts normally.
- R9: When the `sdo` of one instance feeds the `sdi` of a second instance with a shared clock, the pair behaves as a single 2N-bit chain. The second instance's `sdo` then carries bit 2N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sck | input | 1 | Serial shift clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sdi | input | 1 | Serial data into stage 1 |
| load_open | input | 1 | Transfer gate: 1 = holding stage follows chain |
| blank | input | 1 | 1 forces all channels off |
| uv_flag | input | 1 | Supply-undervoltage flag, 1 forces all channels off |
| chan_on | output | CHANNELS | Channel-on vector, bit 0 = channel 1 |
| sdo | output | 1 | Last-stage cascade output, falling-edge retimed |

## Verification
Several properties are checked at every rising clock edge:
- one-step shifting of the chain;
- `sdo` equal to stage N just before the edge;
- the open holding stage equal to the chain;
- all channels off under blanking or undervoltage;
- cleared outputs during reset.

Other behaviour can only be shown by the bench's scenarios against its two-instance model:
- that the held pattern survives long shift sequences with the gate closed;
- that it reappears after a force-off;
- that a rising edge right after reset release is ignored;
- that `sdo` has not yet moved while the clock is high;
- that two cascaded instances form one 32-bit chain.

// File: rtl/ledsink_pkg.sv
package ledsink_pkg;

  typedef struct packed {
    logic blank;
    logic uv;
  } ls_force_t;

  // Channels may conduct only when no force-off source is active.
  function automatic logic ls_drive_allowed(ls_force_t f);
    return !(f.blank || f.uv);
  endfunction

endpackage

// File: rtl/ledsink_rst_sync.sv
module ledsink_rst_sync (
  input  logic sck,
  input  logic rst_n,
  output logic srst_n
);
  // Clear asserts at once; release is taken on a falling edge so the
  // following rising edge already sees a settled, released chain.
  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) srst_n <= 1'b0;
    else        srst_n <= 1'b1;
  end
endmodule

// File: rtl/ledsink_shift.sv
module ledsink_shift #(
  parameter int unsigned N = 16
) (
  input  logic         sck,
  input  logic         srst_n,
  input  logic         sdi,
  output logic [N-1:0] stage,
  output logic         last
);
  function automatic logic [N-1:0] shift_next(logic [N-1:0] cur, logic din);
    return {cur[N-2:0], din};
  endfunction

  always_ff @(posedge sck or negedge srst_n) begin
    if (!srst_n) stage <= '0;
    else         stage <= shift_next(stage, sdi);
  end

  assign last = stage[N-1];

  // R1: one rising edge moves the chain by exactly one position
  p_shift_step_r1: assert property (@(posedge sck) disable iff (!srst_n)
    $past(srst_n) |-> stage == {$past(stage[N-2:0]), $past(sdi)});
endmodule

// File: rtl/ledsink_latch.sv
module ledsink_latch #(
  parameter int unsigned N = 16
) (
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_latch begin
    if (!rst_n)      q = '0;
    else if (open_i) q = d;
  end
endmodule

// File: rtl/ledsink_cascade_out.sv
module ledsink_cascade_out (
  input  logic sck,
  input  logic rst_n,
  input  logic last,
  output logic sdo
);
  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n) sdo <= 1'b0;
    else        sdo <= last;
  end

  // R6: at each rising edge the output shows the stage value from before that edge
  p_sdo_last_r6: assert property (@(posedge sck) disable iff (!rst_n)
    $past(rst_n) |-> sdo == last);
endmodule

// File: rtl/ledsink_ctrl.sv
module ledsink_ctrl
  import ledsink_pkg::*;
#(
  parameter int unsigned CHANNELS = 16
) (
  input  logic                sck,
  input  logic                rst_n,
  input  logic                sdi,
  input  logic                load_open,
  input  logic                blank,
  input  logic                uv_flag,
  output logic [CHANNELS-1:0] chan_on,
  output logic                sdo
);
  localparam int unsigned LAST = CHANNELS - 1;

  logic                srst_n;
  logic [CHANNELS-1:0] stage;
  logic                stage_last;
  logic [CHANNELS-1:0] held;
  logic                drive_ok;
  ls_force_t           force_in;

  ledsink_rst_sync u_sync (
    .sck(sck), .rst_n(rst_n), .srst_n(srst_n)
  );

  ledsink_shift #(.N(CHANNELS)) u_shift (
    .sck(sck), .srst_n(srst_n), .sdi(sdi), .stage(stage), .last(stage_last)
  );

  ledsink_latch #(.N(CHANNELS)) u_hold (
    .rst_n(rst_n), .open_i(load_open), .d(stage), .q(held)
  );

  ledsink_cascade_out u_out (
    .sck(sck), .rst_n(rst_n), .last(stage_last), .sdo(sdo)
  );

  assign force_in = '{blank: blank, uv: uv_flag};
  assign drive_ok = ls_drive_allowed(force_in);

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    assign chan_on[i] = held[i] & drive_ok;
  end

  // R2: an open transfer gate makes the holding stage mirror the chain
  p_follow_open_r2: assert property (@(posedge sck) disable iff (!rst_n)
    load_open |-> held == stage);

  // R3: blanking empties the channel vector
  p_blank_off_r3: assert property (@(posedge sck) disable iff (!rst_n)
    blank |-> chan_on == '0);

  // R4: undervoltage empties the channel vector
  p_uv_off_r4: assert property (@(posedge sck) disable iff (!rst_n)
    uv_flag |-> chan_on == '0);

  // R5: during reset the channels and the cascade output read zero
  always @(posedge sck) begin
    if (rst_n == 1'b0) begin
      p_reset_clear_r5: assert (chan_on == '0 && sdo == 1'b0 && stage[LAST] == 1'b0);
    end
  end
endmodule

// File: tb/sim_ledsink_ctrl.sv
module sim_ledsink_ctrl;
  localparam int N = 16;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  logic run, sdi, le, blank, uv, rst_n;
  logic sck;
  logic [N-1:0] chan0, chan1;
  logic sdo0, sdo1;

  assign sck = clk & run;

  always #5 clk = ~clk;

  ledsink_ctrl #(.CHANNELS(N)) u0 (
    .sck(sck), .rst_n(rst_n), .sdi(sdi), .load_open(le), .blank(blank),
    .uv_flag(uv), .chan_on(chan0), .sdo(sdo0)
  );
  ledsink_ctrl #(.CHANNELS(N)) u1 (
    .sck(sck), .rst_n(rst_n), .sdi(sdo0), .load_open(le), .blank(blank),
    .uv_flag(uv), .chan_on(chan1), .sdo(sdo1)
  );

  // {blank, uv, 32-bit pattern shifted MSB first}
  localparam logic [W+1:0] VEC [6] = '{
    {2'b00, 32'hA5C3_0F81},
    {2'b10, 32'hFFFF_0001},
    {2'b00, 32'h8000_0001},
    {2'b01, 32'h1234_ABCD},
    {2'b00, 32'h0000_FFFF},
    {2'b11, 32'h6DB6_DB6D}
  };

  int n_vec = 0;
  int n_bad = 0;

  // reference model of the two-instance chain
  logic [W-1:0] m_sr = '0;
  logic [N-1:0] m_l0 = '0, m_l1 = '0;
  logic m_sdo0 = 1'b0, m_sdo1 = 1'b0, m_rq = 1'b0;
  logic prev_run = 1'b0, prev_rst = 1'b0;
  logic [N-1:0] s_chan0, s_chan1;
  logic s_sdo1;

  task automatic chk16(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic r, input logic l, input logic b,
                      input logic u, input logic rs, input logic probe, input string tag);
    logic [N-1:0] gate;
    @(negedge clk);
    if (prev_run && prev_rst) begin
      m_rq   = 1'b1;
      m_sdo0 = m_sr[N-1];
      m_sdo1 = m_sr[W-1];
    end
    #1;
    sdi = d; run = r; le = l; blank = b; uv = u; rst_n = rs;
    if (!rs) begin
      m_sr = '0; m_l0 = '0; m_l1 = '0; m_sdo0 = 1'b0; m_sdo1 = 1'b0; m_rq = 1'b0;
    end
    if (rs && l) begin
      m_l0 = m_sr[N-1:0];
      m_l1 = m_sr[W-1:N];
    end
    #3;
    gate = (b || u) ? '0 : '1;
    s_chan0 = chan0; s_chan1 = chan1; s_sdo1 = sdo1;
    chk16(chan0, m_l0 & gate, {tag, " dev0"});
    chk16(chan1, m_l1 & gate, {tag, " dev1 R9"});
    chk1(sdo1, m_sdo1, {tag, " cascade sdo R9"});
    if (probe) begin
      #3;
      chk1(sdo1, m_sdo1, "R6 sdo moved before falling edge");
    end
    if (r && m_rq) m_sr = {m_sr[W-2:N], m_sdo0, m_sr[N-2:0], d};
    if (rs && l) begin
      m_l0 = m_sr[N-1:0];
      m_l1 = m_sr[W-1:N];
    end
    prev_run = r;
    prev_rst = rs;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    run = 1'b0; sdi = 1'b0; le = 1'b0; blank = 1'b0; uv = 1'b0; rst_n = 1'b0;
    // R5 reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 reset state");
    chk16(s_chan0, 16'h0000, "R5 channels cleared");
    // R8 release: first rising edge ignored, next one shifts
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 release");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 after release");
    chk16(s_chan0, 16'h0000, "R8 edge before falling edge must not shift");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7 single one");
    chk16(s_chan0, 16'h0001, "R7 stage 1 maps to bit 0");

    // table walk: shift with gate closed, then transfer with forces from table
    for (int v = 0; v < 6; v++) begin
      for (int k = W - 1; k >= 0; k--)
        step(VEC[v][k], 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 R2 hold while shifting");
      step(1'b0, 1'b0, 1'b1, VEC[v][W+1], VEC[v][W], 1'b1, 1'b0, "R3 R4 R9 transfer");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 R4 pattern restored");
      chk16({s_chan1, s_chan0} >> N, VEC[v][W-1:N], "R9 upper device pattern");
      chk16(s_chan0, VEC[v][N-1:0], "R7 lower device pattern");
    end

    // transparent gate while shifting
    for (int k = 0; k < 24; k++)
      step(k[0] ^ k[2], 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 follow while open");

    // falling-edge retiming of the cascade output
    for (int k = 0; k < 40; k++)
      step(k[0], 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 alternating");

    // forces applied in the same cycle as an open gate with live data
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R3 blank same cycle");
    chk16(s_chan0, 16'h0000, "R3 blank forces off");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 uv same cycle");
    chk16(s_chan1, 16'h0000, "R4 uv forces off");

    // reset in the middle of operation, with no clock running
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R5 before reset");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 async clear");
    chk16(s_chan0 | s_chan1, 16'h0000, "R5 asynchronous clear");
    chk1(s_sdo1, 1'b0, "R5 sdo cleared");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 second release");
    for (int k = 0; k < 5; k++)
      step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 R8 refill");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1 refill result");
    chk16(s_chan0, 16'h001F, "R8 five shifts after release");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule